// File: doc/BRIEF.md
# 8x8 Multiplier Tile with Per-Bit Bypassable Registers

This block models a hard multiplier tile. It multiplies two 8-bit unsigned operands and gives a 16-bit product. A flip-flop on the tile clock captures every operand bit on every cycle. A second flip-flop captures every bit of the core product on every cycle. A 2:1 mux on each of those bits chooses whether the registered copy or the live value goes forward. The configuration therefore sets the delay between an operand and the product bit it reaches. That delay is zero, one or two cycles, and it can differ from bit to bit.

The 32 select bits live in a configuration shift chain. The chain is loaded one bit per cycle through a serial input while a shift enable is high. Its top bit leaves on a serial output, so several tiles can be daisy-chained. The data pins are plain. The tile consumes an operand pair on every cycle and drives a product on every cycle. There is no stall: the latency is a fixed property of the loaded configuration, not something negotiated at run time. To move to a new configuration, shift in the new word. The product is then valid once the newly selected registers have been refilled.

Top module: `mul8_bypass_tile`

## Requirements
- R1: With every select bit 0 (bypass), `prod` equals the unsigned product `op_a * op_b` in the same cycle, including 0, 1 and 255x255 = 65025.
- R2: With every select bit 1 (registered), `prod` equals the product of the operands that were present at the clock edge two edges earlier.
- R3: With both operand selects at 1 and all product selects at 0 (configuration word 0x0000FFFF), `prod` shows the product of the operands from the previous edge.
- R4: With the operand selects at 0 and all product selects at 1 (configuration word 0xFFFF0000), `prod` is the product of the current operands as captured at the last edge, i.e. a one-cycle delay.
- R5: Each select bit acts alone. Configuration bit i (0..7) picks the registered copy of `op_a[i]`. Bit 8+i picks the registered copy of `op_b[i]`. Bit 16+j (j = 0..15) picks the registered copy of product bit j. A value of 1 means registered and 0 means bypass. Mixed words give a per-bit mixture of delayed and live values.
- R6: On each rising edge with `cfg_shift_en` high, the chain shifts one place towards its top bit and loads `cfg_shift_in` into bit 0. `cfg_shift_out` always shows bit 31. After 32 shifts, the first bit sent in sits at bit 31.
- R7: While `cfg_shift_en` is low, the configuration and `cfg_shift_out` hold, whatever `cfg_shift_in` does.
- R8: A synchronous active-high `rst` clears all operand and product registers to 0 on the edge where it is sampled high. It leaves the configuration unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tile clock for all registers and the configuration chain |
| rst | input | 1 | Synchronous active-high clear of operand and product registers |
| cfg_shift_en | input | 1 | Shift the configuration chain by one bit this cycle |
| cfg_shift_in | input | 1 | Serial configuration bit entering chain bit 0 |
| cfg_shift_out | output | 1 | Chain bit 31, for daisy-chaining |
| op_a | input | 8 | Unsigned multiplicand |
| op_b | input | 8 | Unsigned multiplier |
| prod | output | 16 | Product after the selected per-bit registers |

## Verification
Every cycle, the assertions check four things. The shift-and-add core must match an exact unsigned multiply. An all-bypass configuration must give the same-cycle product at the pins. An all-registered configuration that has run free of reset for two edges must give the operands from two edges earlier. The chain must not move while shifting is disabled. Some behaviours can only be shown by the bench's scenarios, which replay operand tables under several configuration words against a per-bit timing model. Those are the one-cycle modes, the mixed per-bit words where a delayed `op_a` meets a live `op_b`, the clearing effect of a reset on the pipeline, and the retained configuration after reset.

// File: rtl/mul8_tile_pkg.sv
package mul8_tile_pkg;

  localparam int unsigned DEF_OP_W = 8;

  function automatic int unsigned prod_width(input int unsigned op_w);
    return 2 * op_w;
  endfunction

  function automatic int unsigned cfg_width(input int unsigned op_w);
    return 2 * op_w + prod_width(op_w);
  endfunction

endpackage

// File: rtl/mul8_cfg_chain.sv
module mul8_cfg_chain #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         shift_in,
  output logic         shift_out,
  output logic [W-1:0] cfg
);

  logic [W-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (shift_en) begin
      chain_q <= {chain_q[W-2:0], shift_in};
    end
  end

  assign cfg       = chain_q;
  assign shift_out = chain_q[W-1];

  // R7
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(shift_en) |-> (chain_q == $past(chain_q)));

endmodule

// File: rtl/mul8_bypass_reg.sv
module mul8_bypass_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] sel,
  input  logic [W-1:0] d,
  output logic [W-1:0] y
);

  logic [W-1:0] q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) q[i] <= 1'b0;
      else     q[i] <= d[i];
    end
    assign y[i] = sel[i] ? q[i] : d[i];
  end

endmodule

// File: rtl/mul8_core.sv
module mul8_core #(
  parameter int unsigned OP_W = 8,
  localparam int unsigned PW = 2 * OP_W
) (
  input  logic [OP_W-1:0] a,
  input  logic [OP_W-1:0] b,
  output logic [PW-1:0]   y
);

  logic [PW-1:0] acc [OP_W+1];
  assign acc[0] = '0;

  for (genvar i = 0; i < OP_W; i++) begin : g_row
    logic [PW-1:0] row;
    assign row      = b[i] ? (PW'(a) << i) : '0;
    assign acc[i+1] = acc[i] + row;
  end

  assign y = acc[OP_W];

  // R1
  always_comb begin
    if (!$isunknown({a, b})) begin
      core_exact_chk: assert (y == PW'(a) * PW'(b));
    end
  end

endmodule

// File: rtl/mul8_bypass_tile.sv
module mul8_bypass_tile #(
  parameter int unsigned OP_W = mul8_tile_pkg::DEF_OP_W,
  localparam int unsigned PW = mul8_tile_pkg::prod_width(OP_W),
  localparam int unsigned CW = mul8_tile_pkg::cfg_width(OP_W)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_shift_en,
  input  logic            cfg_shift_in,
  output logic            cfg_shift_out,
  input  logic [OP_W-1:0] op_a,
  input  logic [OP_W-1:0] op_b,
  output logic [PW-1:0]   prod
);

  logic [CW-1:0]   cfg;
  logic [OP_W-1:0] a_sel, b_sel, a_eff, b_eff;
  logic [PW-1:0]   y_sel, core_y;

  mul8_cfg_chain #(.W(CW)) u_cfg (
    .clk(clk), .rst(rst), .shift_en(cfg_shift_en), .shift_in(cfg_shift_in),
    .shift_out(cfg_shift_out), .cfg(cfg)
  );

  assign a_sel = cfg[OP_W-1:0];
  assign b_sel = cfg[2*OP_W-1:OP_W];
  assign y_sel = cfg[CW-1:2*OP_W];

  mul8_bypass_reg #(.W(OP_W)) u_areg (
    .clk(clk), .rst(rst), .sel(a_sel), .d(op_a), .y(a_eff)
  );

  mul8_bypass_reg #(.W(OP_W)) u_breg (
    .clk(clk), .rst(rst), .sel(b_sel), .d(op_b), .y(b_eff)
  );

  mul8_core #(.OP_W(OP_W)) u_core (
    .a(a_eff), .b(b_eff), .y(core_y)
  );

  mul8_bypass_reg #(.W(PW)) u_yreg (
    .clk(clk), .rst(rst), .sel(y_sel), .d(core_y), .y(prod)
  );

  // Checker state: clean all-registered cycles since reset (saturating).
  logic [1:0] full_run_q;
  always_ff @(posedge clk) begin
    if (rst || !(&cfg))          full_run_q <= 2'd0;
    else if (full_run_q != 2'd3) full_run_q <= full_run_q + 2'd1;
  end

  // R1
  bypass_comb_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg == '0) |-> (prod == PW'(op_a) * PW'(op_b)));

  // R2
  full_pipe_chk: assert property (@(posedge clk) disable iff (rst)
    ((&cfg) && (full_run_q >= 2'd2)) |->
      (prod == PW'($past(op_a, 2)) * PW'($past(op_b, 2))));

endmodule

// File: tb/mul8_bypass_tile_tb.sv
module mul8_bypass_tile_tb;

  logic        clk = 1'b0;
  logic        rst, sh_en, sh_in;
  logic [7:0]  op_a, op_b;
  logic [15:0] prod;
  logic        sh_out;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  // Bench model state, from the requirements
  logic [7:0]  ma, mb;
  logic [15:0] my;
  logic [31:0] mcfg;

  always #5 clk = ~clk;

  mul8_bypass_tile u_dut (
    .clk(clk), .rst(rst), .cfg_shift_en(sh_en), .cfg_shift_in(sh_in),
    .cfg_shift_out(sh_out), .op_a(op_a), .op_b(op_b), .prod(prod)
  );

  localparam logic [15:0] PAIRS [12] = '{
    16'h0000, 16'h0101, 16'hFFFF, 16'h01FF, 16'hFF01, 16'h8002,
    16'h0F10, 16'hAA55, 16'h7F7F, 16'h00C3, 16'h1234, 16'hC80D
  };
  localparam logic [31:0] MODES [6] = '{
    32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_FFFF,
    32'hFFFF_0000, 32'h0000_00FF, 32'h5555_00F0
  };
  localparam string MTAG [6] = '{"R1", "R2", "R3", "R4", "R5", "R5"};

  function automatic logic [15:0] model_core(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] ea, eb;
    ea = (mcfg[7:0] & ma) | (~mcfg[7:0] & a);
    eb = (mcfg[15:8] & mb) | (~mcfg[15:8] & b);
    return 16'(ea) * 16'(eb);
  endfunction

  function automatic logic [15:0] model_out(input logic [7:0] a, input logic [7:0] b);
    return (mcfg[31:16] & my) | (~mcfg[31:16] & model_core(a, b));
  endfunction

  task automatic check16(input logic [15:0] act, input logic [15:0] exp, input string tag);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [7:0] a, input logic [7:0] b, input logic r,
                      input logic en, input logic si, input bit chk, input string tag);
    logic [15:0] c;
    @(negedge clk);
    op_a = a; op_b = b; rst = r; sh_en = en; sh_in = si;
    #1;
    if (chk) check16(prod, model_out(a, b), tag);
    c = model_core(a, b);
    @(posedge clk);
    if (r) begin ma = '0; mb = '0; my = '0; end
    else   begin ma = a; mb = b; my = c; end
    if (en) mcfg = {mcfg[30:0], si};
  endtask

  task automatic load_cfg(input logic [31:0] w);
    for (int i = 31; i >= 0; i--) step(8'h00, 8'h00, 1'b0, 1'b1, w[i], 1'b0, "");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    ma = '0; mb = '0; my = '0; mcfg = '0;
    op_a = '0; op_b = '0; rst = 1'b1; sh_en = 1'b0; sh_in = 1'b0;
    step(8'h00, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, "");
    step(8'h00, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, "");

    // R8: reset state with all-registered config and no operand activity
    load_cfg(32'hFFFF_FFFF);
    step(8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, "R8 reset state");

    // Vector table walk under each configuration word
    for (int m = 0; m < 6; m++) begin
      load_cfg(MODES[m]);
      for (int p = 0; p < 12; p++)
        step(PAIRS[p][15:8], PAIRS[p][7:0], 1'b0, 1'b0, p[0], 1'b1, MTAG[m]);
    end

    // R6: bit order of the chain
    load_cfg(32'h8000_0001);
    #1; vectors++;
    if (sh_out !== 1'b1) begin miscompares++;
      $display("FAIL R6 actual=%b expected=1", sh_out); end
    step(8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, "");
    #1; vectors++;
    if (sh_out !== 1'b0) begin miscompares++;
      $display("FAIL R6 actual=%b expected=0", sh_out); end

    // R7: chain holds while disabled; behaviour under word 0x00000002 persists
    for (int k = 0; k < 3; k++) step(8'h03, 8'h05, 1'b0, 1'b0, 1'b1, 1'b1, "R7 hold");
    vectors++;
    if (sh_out !== 1'b0) begin miscompares++;
      $display("FAIL R7 actual=%b expected=0", sh_out); end

    // R8: reset clears pipeline, configuration survives
    load_cfg(32'hFFFF_FFFF);
    step(8'd200, 8'd200, 1'b0, 1'b0, 1'b0, 1'b0, "");
    step(8'd200, 8'd200, 1'b0, 1'b0, 1'b0, 1'b1, "R8 pre-reset");
    step(8'd200, 8'd200, 1'b0, 1'b0, 1'b0, 1'b1, "R8 pre-reset 40000");
    step(8'd200, 8'd200, 1'b1, 1'b0, 1'b0, 1'b0, "");
    step(8'd200, 8'd200, 1'b0, 1'b0, 1'b0, 1'b1, "R8 cleared");
    check16(prod, 16'h0000, "R8 cleared literal");
    step(8'd3, 8'd5, 1'b0, 1'b0, 1'b0, 1'b1, "R8 refill");
    step(8'd3, 8'd5, 1'b0, 1'b0, 1'b0, 1'b1, "R8 config kept");
    check16(prod, 16'd40000, "R8 config kept literal");
    step(8'd3, 8'd5, 1'b0, 1'b0, 1'b0, 1'b1, "R8 config kept 15");
    check16(prod, 16'd15, "R2 two-cycle literal");

    // R1: corner literal in bypass
    load_cfg(32'h0000_0000);
    step(8'hFF, 8'hFF, 1'b0, 1'b0, 1'b0, 1'b1, "R1 max");
    check16(prod, 16'd65025, "R1 max literal");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule